// File: doc/BRIEF.md
# Paged SPI LED-Matrix Register Slave

This block is the register front end of an RGB LED matrix controller with 6 rows and 11 columns, reached over a four-wire SPI link. Each frame opens with a command byte. That byte carries a direction flag, a fixed chip identity and a page selector. A start-address byte comes next. In a write frame, data bytes follow and are stored at consecutive addresses. In a read frame, the slave returns one byte on MISO.

There are three pages. The first holds one duty byte per colour channel. The second holds one current-scale byte per colour channel. The third holds a small set of function registers. A display engine fetches the duty and scale values for any channel through a parallel lookup port. A write of a magic value to a dedicated reset register returns every page to zero.

The SPI pins are oversampled by the block clock. The shutdown input and the software enable bit together gate the LED enable output.

Top module: `spi_led_regs`

## Requirements
- R1: Command byte fields: bit 7 is the direction (1 = read, 0 = write), bits 6:4 are the chip identity, and bits 3:0 select the page (0 = duty, 1 = scale, 2 = function).
- R2: A frame whose identity field is not 3'b101 is ignored. It changes no register, and a read frame with such an identity returns 0x00.
- R3: Duty page: channel n (0..197) sits at address n+1. A write burst stores its data bytes at the start address, then the start address plus one, and so on. The stored value appears on `pixPwm` when `pixIndex` = n.
- R4: The scale page uses the same address layout as the duty page, and its values appear on `pixScale`.
- R5: Writes to invalid locations are dropped, and reads of them return 0x00. Invalid locations are address 0 and addresses above 198 on the duty and scale pages, function addresses other than 0x00, 0x01, 0x02 and 0x25, and pages 3 to 15.
- R6: The function page holds configuration at 0x00, global current at 0x01, pull control at 0x02 and spread control at 0x25. Each reads back what was written. `globalCurrent` shows the value at 0x01.
- R7: Writing 0xAE to function address 0x2F clears every register on every page. Writing any other value to 0x2F has no effect.
- R8: `ledEnable` is high only when configuration bit 0 is 1 and `shutdownN` is 1.
- R9: A read frame returns the addressed byte MSB first during the third byte, in SPI mode 0. MISO is 0 while chip select is high.
- R10: Raising chip select mid-frame discards the partial frame. The next frame starts again with a command byte.
- R11: After reset, every register is zero, `spiMiso` is 0 and `ledEnable` is 0.
- R12: The address counter stops at 0xFF and does not wrap, so a long burst cannot reach address 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples SPI |
| rstN | input | 1 | Asynchronous active-low reset |
| spiSclk | input | 1 | SPI clock, mode 0 |
| spiCsN | input | 1 | SPI chip select, active low |
| spiMosi | input | 1 | SPI data in |
| spiMiso | output | 1 | SPI data out |
| shutdownN | input | 1 | Hardware shutdown, active low |
| pixIndex | input | 8 | Channel index for the parallel lookup |
| pixPwm | output | 8 | Duty value of the indexed channel |
| pixScale | output | 8 | Scale value of the indexed channel |
| ledEnable | output | 1 | LED drive enable |
| globalCurrent | output | 8 | Global current register |

## Verification
The bench probes both ends of the channel range: address 0 and address 199 must be dropped, while addresses 1 and 198 must land. An off-by-one in the base address would move the data to the wrong pixel. It sends frames carrying a wrong identity and frames aborted in the middle of a byte. A design that ignored the identity, or that kept partial bits after chip select rose, would corrupt storage. A burst that starts at 0xFE checks saturation: a wrapping counter would overwrite the configuration register. The reset register is written first with a non-magic value and then with 0xAE, which catches a design that clears on any write to that address.

// File: rtl/spi_led_pkg.sv
package spi_led_pkg;
  localparam logic [3:0] PAGE_PWM   = 4'd0;
  localparam logic [3:0] PAGE_SCALE = 4'd1;
  localparam logic [3:0] PAGE_FUNC  = 4'd2;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic       idle;   // chip select high (synchronised)
    logic       wr;     // store data at page/addr
    logic       ld;     // load read value into MISO shifter
    logic       shift;  // advance MISO shifter
    logic [3:0] page;
    logic [7:0] addr;
    logic [7:0] data;
  } strobe_t;
endpackage

// File: rtl/spi_led_ctrl.sv
module spi_led_ctrl
  import spi_led_pkg::*;
#(
  parameter logic [2:0] CHIP_ID = 3'b101,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    spiSclk,
  input  logic    spiCsN,
  input  logic    spiMosi,
  output strobe_t st
);
  typedef enum logic [1:0] {B_CMD, B_ADDR, B_DATA} byte_e;

  logic [SYNC_STAGES-1:0] sclkSync, csSync, mosiSync;
  logic sclkPrev;
  logic [2:0] bitCnt;
  byte_e byteIdx;
  logic [6:0] shReg;
  logic [7:0] cmdReg, addrReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      mosiSync <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], spiSclk};
      csSync   <= {csSync[SYNC_STAGES-2:0], spiCsN};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], spiMosi};
      sclkPrev <= sclkSync[SYNC_STAGES-1];
    end
  end

  logic idle, rise, fall, byteDone, idOk, isRead;
  logic [7:0] byteVal;

  always_comb begin
    idle     = csSync[SYNC_STAGES-1];
    rise     = sclkSync[SYNC_STAGES-1] & ~sclkPrev;
    fall     = ~sclkSync[SYNC_STAGES-1] & sclkPrev;
    byteVal  = {shReg, mosiSync[SYNC_STAGES-1]};
    byteDone = rise && !idle && (bitCnt == 3'd7);
    idOk     = (cmdReg[6:4] == CHIP_ID);
    isRead   = cmdReg[7];
    st.idle  = idle;
    st.page  = cmdReg[3:0];
    st.addr  = (byteIdx == B_ADDR) ? byteVal : addrReg;
    st.data  = byteVal;
    st.wr    = byteDone && (byteIdx == B_DATA) && idOk && !isRead;
    st.ld    = byteDone && (byteIdx == B_ADDR) && idOk && isRead;
    st.shift = fall && !idle && (bitCnt != 3'd0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      byteIdx <= B_CMD;
      shReg   <= '0;
      cmdReg  <= '0;
      addrReg <= '0;
    end else if (idle) begin
      bitCnt  <= '0;
      byteIdx <= B_CMD;
    end else if (rise) begin
      shReg  <= byteVal[6:0];
      bitCnt <= bitCnt + 3'd1;
      if (byteDone) begin
        case (byteIdx)
          B_CMD:  begin cmdReg <= byteVal; byteIdx <= B_ADDR; end
          B_ADDR: begin addrReg <= byteVal; byteIdx <= B_DATA; end
          default: if (addrReg != 8'hFF) addrReg <= addrReg + 8'd1;
        endcase
      end
    end
  end

  // R10: an idle chip select leaves the frame state at its start
  assert_abort_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    idle |=> (bitCnt == 3'd0 && byteIdx == B_CMD));
  // R12: the counter holds once it has reached the top
  assert_addr_saturates_R12: assert property (@(posedge clk) disable iff (!rstN)
    (byteIdx == B_DATA && addrReg == 8'hFF) |=> addrReg == 8'hFF);
  // R9: load and shift never coincide
  assert_ld_shift_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(st.ld && st.shift));
endmodule

// File: rtl/spi_led_dpath.sv
module spi_led_dpath
  import spi_led_pkg::*;
#(
  parameter int NUM_CH = 198,
  parameter int IDX_W = 8,
  parameter logic [7:0] RESET_MAGIC = 8'hAE
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic [IDX_W-1:0] pixIndex,
  output logic [7:0]       pixPwm,
  output logic [7:0]       pixScale,
  output logic [7:0]       cfgReg,
  output logic [7:0]       gccReg,
  output logic             miso
);
  localparam logic [7:0] ADDR_CFG    = 8'h00;
  localparam logic [7:0] ADDR_GCC    = 8'h01;
  localparam logic [7:0] ADDR_PULL   = 8'h02;
  localparam logic [7:0] ADDR_SPREAD = 8'h25;
  localparam logic [7:0] ADDR_RST    = 8'h2F;
  localparam logic [7:0] LAST_ADDR   = 8'(NUM_CH);

  logic [7:0] pwmMem [NUM_CH];
  logic [7:0] scaleMem [NUM_CH];
  logic [7:0] pullReg, spreadReg, misoReg, readVal;
  logic [7:0] chanIdx;
  logic chanOk, softRst, wrPwm, wrScale, wrFunc;

  always_comb begin
    chanOk  = (st.addr != 8'd0) && (st.addr <= LAST_ADDR);
    chanIdx = st.addr - 8'd1;
    wrFunc  = st.wr && (st.page == PAGE_FUNC);
    wrPwm   = st.wr && (st.page == PAGE_PWM) && chanOk;
    wrScale = st.wr && (st.page == PAGE_SCALE) && chanOk;
    softRst = wrFunc && (st.addr == ADDR_RST) && (st.data == RESET_MAGIC);
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pwmMem[i]   <= '0;
        scaleMem[i] <= '0;
      end else if (softRst) begin
        pwmMem[i]   <= '0;
        scaleMem[i] <= '0;
      end else begin
        if (wrPwm && chanIdx == 8'(i))   pwmMem[i]   <= st.data;
        if (wrScale && chanIdx == 8'(i)) scaleMem[i] <= st.data;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN || softRst) begin
      cfgReg <= '0; gccReg <= '0; pullReg <= '0; spreadReg <= '0;
    end else if (wrFunc) begin
      case (st.addr)
        ADDR_CFG:    cfgReg    <= st.data;
        ADDR_GCC:    gccReg    <= st.data;
        ADDR_PULL:   pullReg   <= st.data;
        ADDR_SPREAD: spreadReg <= st.data;
        default: ;
      endcase
    end
  end

  always_comb begin
    readVal = 8'h00;
    case (st.page)
      PAGE_PWM:   if (chanOk) readVal = pwmMem[chanIdx];
      PAGE_SCALE: if (chanOk) readVal = scaleMem[chanIdx];
      PAGE_FUNC:
        case (st.addr)
          ADDR_CFG:    readVal = cfgReg;
          ADDR_GCC:    readVal = gccReg;
          ADDR_PULL:   readVal = pullReg;
          ADDR_SPREAD: readVal = spreadReg;
          default:     readVal = 8'h00;
        endcase
      default: readVal = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         misoReg <= '0;
    else if (st.idle)  misoReg <= '0;
    else if (st.ld)    misoReg <= readVal;
    else if (st.shift) misoReg <= {misoReg[6:0], 1'b0};
  end
  assign miso = misoReg[7];

  always_comb begin
    pixPwm   = 8'h00;
    pixScale = 8'h00;
    if (32'(pixIndex) < NUM_CH) begin
      pixPwm   = pwmMem[pixIndex];
      pixScale = scaleMem[pixIndex];
    end
  end

  // R9: MISO is quiet after an idle cycle
  assert_idle_miso_R9: assert property (@(posedge clk) disable iff (!rstN)
    st.idle |=> !miso);
  // R6: configuration only moves on a function-page write
  assert_cfg_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    !wrFunc |=> $stable(cfgReg));
  // R7: the magic write clears the function page and channel storage
  assert_soft_reset_R7: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (cfgReg == 8'h00 && gccReg == 8'h00 && pwmMem[0] == 8'h00));
endmodule

// File: rtl/spi_led_regs.sv
module spi_led_regs
  import spi_led_pkg::*;
#(
  parameter int ROWS = 6,
  parameter int COLS = 11,
  parameter int CHANS_PER_LED = 3,
  parameter logic [2:0] CHIP_ID = 3'b101,
  parameter logic [7:0] RESET_MAGIC = 8'hAE,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_CH = ROWS * COLS * CHANS_PER_LED,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             spiSclk,
  input  logic             spiCsN,
  input  logic             spiMosi,
  output logic             spiMiso,
  input  logic             shutdownN,
  input  logic [IDX_W-1:0] pixIndex,
  output logic [7:0]       pixPwm,
  output logic [7:0]       pixScale,
  output logic             ledEnable,
  output logic [7:0]       globalCurrent
);
  strobe_t st;
  logic [7:0] cfgReg;

  spi_led_ctrl #(.CHIP_ID(CHIP_ID), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .st(st));

  spi_led_dpath #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .RESET_MAGIC(RESET_MAGIC)) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .pixIndex(pixIndex), .pixPwm(pixPwm),
    .pixScale(pixScale), .cfgReg(cfgReg), .gccReg(globalCurrent), .miso(spiMiso));

  assign ledEnable = cfgReg[0] & shutdownN;

  // R8: enable never shows while shutdown is held
  assert_enable_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    !shutdownN |-> !ledEnable);
endmodule

// File: tb/spi_led_regs_bench.sv
module spi_led_regs_bench;
  localparam int HALF = 8;
  logic clk = 0, rstN = 0;
  logic sclk = 0, csN = 1, mosi = 0, shdnN = 1;
  logic miso, ledEn;
  logic [7:0] pixIdx = 0, pwm, scale, gcc;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  spi_led_regs u_spi_led_regs (
    .clk(clk), .rstN(rstN), .spiSclk(sclk), .spiCsN(csN), .spiMosi(mosi),
    .spiMiso(miso), .shutdownN(shdnN), .pixIndex(pixIdx), .pixPwm(pwm),
    .pixScale(scale), .ledEnable(ledEn), .globalCurrent(gcc));

  typedef struct packed {
    logic [3:0] page;
    logic [7:0] addr;
    logic [7:0] wdata;
    logic [7:0] exp;
    logic [7:0] req;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{4'd0, 8'h01, 8'h11, 8'h11, 8'd3},  // R3 first channel
    '{4'd0, 8'hC6, 8'h22, 8'h22, 8'd3},  // R3 last channel
    '{4'd0, 8'h00, 8'h33, 8'h00, 8'd5},  // R5 address 0
    '{4'd0, 8'hC7, 8'h44, 8'h00, 8'd5},  // R5 past the end
    '{4'd1, 8'h05, 8'h55, 8'h55, 8'd4},  // R4 scale page
    '{4'd2, 8'h00, 8'h09, 8'h09, 8'd6},  // R6 configuration
    '{4'd2, 8'h01, 8'h80, 8'h80, 8'd6},  // R6 global current
    '{4'd2, 8'h02, 8'h33, 8'h33, 8'd6},  // R6 pull control
    '{4'd2, 8'h25, 8'h07, 8'h07, 8'd6},  // R6 spread control
    '{4'd2, 8'h03, 8'h5A, 8'h00, 8'd5},  // R5 undefined function address
    '{4'd3, 8'h01, 8'h66, 8'h00, 8'd5}   // R5 page 3
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xferBits(input logic [7:0] tx, input int nBits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nBits; i--) begin
      mosi = tx[i];
      waitClk(HALF);
      sclk = 1;
      rx[i] = miso;
      waitClk(HALF);
      sclk = 0;
    end
  endtask

  task automatic csLow();
    csN = 0; waitClk(HALF);
  endtask

  task automatic csHigh();
    waitClk(HALF); csN = 1; waitClk(2 * HALF);
  endtask

  task automatic spiWrite(input logic [7:0] cmd, input logic [7:0] addr,
                          input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2, input int n);
    logic [7:0] rx;
    logic [7:0] dat [3];
    dat[0] = d0; dat[1] = d1; dat[2] = d2;
    csLow();
    xferBits(cmd, 8, rx);
    xferBits(addr, 8, rx);
    for (int k = 0; k < n; k++) xferBits(dat[k], 8, rx);
    csHigh();
  endtask

  task automatic spiRead(input logic [7:0] cmd, input logic [7:0] addr, output logic [7:0] val);
    logic [7:0] rx;
    csLow();
    xferBits(cmd, 8, rx);
    xferBits(addr, 8, rx);
    xferBits(8'h00, 8, val);
    csHigh();
  endtask

  function automatic logic [7:0] wcmd(input logic [3:0] page);
    return {1'b0, 3'b101, page};  // R1 write command
  endfunction
  function automatic logic [7:0] rcmd(input logic [3:0] page);
    return {1'b1, 3'b101, page};  // R1 read command
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    waitClk(4);
    rstN = 1;
    waitClk(4);
    // R11 reset state
    chk("R11 miso", {7'd0, miso}, 8'h00);
    chk("R11 ledEnable", {7'd0, ledEn}, 8'h00);
    chk("R11 gcc", gcc, 8'h00);
    pixIdx = 8'd0; waitClk(1);
    chk("R11 pwm", pwm, 8'h00);

    // Vector table: write then read back through SPI (R1, R9)
    foreach (VECS[v]) begin
      spiWrite(wcmd(VECS[v].page), VECS[v].addr, VECS[v].wdata, 8'h00, 8'h00, 1);
      spiRead(rcmd(VECS[v].page), VECS[v].addr, rv);
      chk($sformatf("R%0d vector %0d", VECS[v].req, v), rv, VECS[v].exp);
    end
    chk("R6 globalCurrent port", gcc, 8'h80);
    chk("R9 miso idle", {7'd0, miso}, 8'h00);

    // R8 enable gating (configuration bit 0 set above)
    chk("R8 enabled", {7'd0, ledEn}, 8'h01);
    shdnN = 0; waitClk(2);
    chk("R8 shutdown", {7'd0, ledEn}, 8'h00);
    shdnN = 1; waitClk(2);

    // R3 burst with auto-increment, visible on the parallel port
    spiWrite(wcmd(4'd0), 8'h0A, 8'hA1, 8'hA2, 8'hA3, 3);
    pixIdx = 8'd9;  waitClk(1); chk("R3 burst ch9", pwm, 8'hA1);
    pixIdx = 8'd10; waitClk(1); chk("R3 burst ch10", pwm, 8'hA2);
    pixIdx = 8'd11; waitClk(1); chk("R3 burst ch11", pwm, 8'hA3);
    pixIdx = 8'd197; waitClk(1); chk("R3 last ch", pwm, 8'h22);
    pixIdx = 8'd4; waitClk(1); chk("R4 scale ch4", scale, 8'h55);

    // R2 wrong identity: write dropped, read returns zero
    spiWrite({1'b0, 3'b100, 4'd0}, 8'h0A, 8'hEE, 8'h00, 8'h00, 1);
    pixIdx = 8'd9; waitClk(1); chk("R2 write ignored", pwm, 8'hA1);
    spiRead({1'b1, 3'b001, 4'd0}, 8'h0A, rv);
    chk("R2 read zero", rv, 8'h00);

    // R10 abort in the address byte, then a clean frame
    csLow(); xferBits(wcmd(4'd0), 8, rv); xferBits(8'hFF, 4, rv); csHigh();
    spiWrite(wcmd(4'd0), 8'h14, 8'h77, 8'h00, 8'h00, 1);
    pixIdx = 8'd19; waitClk(1); chk("R10 recovered frame", pwm, 8'h77);
    // R10 abort in a data byte
    csLow(); xferBits(wcmd(4'd0), 8, rv); xferBits(8'h1E, 8, rv);
    xferBits(8'hCC, 5, rv); csHigh();
    pixIdx = 8'd29; waitClk(1); chk("R10 partial data dropped", pwm, 8'h00);

    // R12 burst from 0xFE must not wrap into configuration
    spiWrite(wcmd(4'd2), 8'hFE, 8'hF0, 8'hF1, 8'hF2, 3);
    spiRead(rcmd(4'd2), 8'h00, rv);
    chk("R12 no wrap", rv, 8'h09);

    // R7 non-magic value, then magic
    spiWrite(wcmd(4'd2), 8'h2F, 8'h12, 8'h00, 8'h00, 1);
    chk("R7 non-magic keeps gcc", gcc, 8'h80);
    spiWrite(wcmd(4'd2), 8'h2F, 8'hAE, 8'h00, 8'h00, 1);
    chk("R7 gcc cleared", gcc, 8'h00);
    chk("R7 enable cleared", {7'd0, ledEn}, 8'h00);
    pixIdx = 8'd0; waitClk(1); chk("R7 pwm cleared", pwm, 8'h00);
    pixIdx = 8'd4; waitClk(1); chk("R7 scale cleared", scale, 8'h00);
    spiRead(rcmd(4'd2), 8'h25, rv);
    chk("R7 spread cleared", rv, 8'h00);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule